// File: doc/BRIEF.md
# Two-Level Page Table Walker

When a virtual address misses in the translation cache, this block resolves it by reading a two-level page table from memory. A walk request supplies the 32-bit virtual address, the physical base of the current process's top-level table and a process identifier. The walker performs two table reads, one after the other. The first fetches the top-level entry, which names the page that holds the second-level table. The second fetches the leaf entry, which names the page frame. The walker then returns the frame number, its permission bits and the finished physical address. If either entry is marked not present, it returns a page fault instead.

Only one walk is in progress at any time. The read port toward memory uses a valid/ready request, and the read data comes back later with its own valid strobe. The response toward the translation cache stays on the outputs until the requester acknowledges it, and a new request is taken only after that.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read at address `req_root + 4*va[31:22]`.
- R2: When the top-level entry is present, the leaf entry is read at address `{entry[31:12], 12'h000} + 4*va[21:12]`.
- R3: At most one table read is outstanding. `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is sampled high. No further read is issued until `mem_rsp_valid` has returned the data.
- R4: A successful walk sets `rsp_fault=0`. It sets `rsp_pfn` to leaf bits 31:12 and `rsp_paddr` to `{leaf[31:12], va[11:0]}`. It sets `rsp_perm` to `{leaf[6] modified, leaf[5] referenced, leaf[2] user, leaf[1] writable}`.
- R5: A top-level entry with bit 0 (present) clear ends the walk with `rsp_fault=1` and `rsp_level=0`, and no leaf read is issued.
- R6: A leaf entry with bit 0 clear ends the walk with `rsp_fault=1` and `rsp_level=1`.
- R7: Every response carries the walk's virtual address on `rsp_vaddr` and its process identifier on `rsp_pid`.
- R8: `rsp_valid` and all response fields hold steady until `rsp_ack` is sampled high. On the next cycle the walker is idle again.
- R9: `req_ready` is high only when the walker is idle. Changes on the request inputs while a walk is busy have no effect on that walk.
- R10: A `mem_rsp_valid` pulse that arrives while no read is outstanding is ignored.
- R11: After reset, `req_ready=1`, `mem_rd_valid=0` and `rsp_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Physical base of the top-level table |
| req_pid | input | PID_W | Process identifier |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Walk result present |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Page fault |
| rsp_level | output | 1 | Fault level: 0 top, 1 leaf |
| rsp_vaddr | output | 32 | Walked virtual address |
| rsp_pid | output | PID_W | Walked process identifier |
| rsp_pfn | output | 20 | Page frame number |
| rsp_perm | output | 4 | Modified, referenced, user, writable |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The bench builds the walker with its default 10/10/12 split and an 8-bit process identifier. With these values, real addresses reach both ends of each index, including the last entry of a table at offset 0xFFC and the all-ones address. Within that build, the bench varies read-ready gaps, read latency and acknowledge delay. It also injects stray read responses and changes the request inputs while a walk is busy. Each of the fault levels, and faults on entries whose other bits are set, are reached in these conditions.

// File: rtl/pt_walker_pkg.sv
// Shared types and entry bit positions for the page table walker.
package pt_walker_pkg;
    localparam int PTE_W       = 32;
    localparam int PTE_PRESENT = 0;
    localparam int PTE_WRITE   = 1;
    localparam int PTE_USER    = 2;
    localparam int PTE_REF     = 5;
    localparam int PTE_MOD     = 6;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RD_TOP,
        WS_WAIT_TOP,
        WS_RD_LEAF,
        WS_WAIT_LEAF,
        WS_DONE,
        WS_FAULT
    } walk_state_e;

    typedef struct packed {
        logic modified;
        logic referenced;
        logic user;
        logic writable;
    } perm_t;
endpackage

// File: rtl/pt_va_split.sv
// Splits a virtual address into per-level table indices and the page offset.
// Assumes two levels of equal index width above the offset.
module pt_va_split #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int LEVELS = 2,
    localparam int VA_W = LEVELS*IDX_W + OFF_W
) (
    input  logic [VA_W-1:0]  va,
    output logic [IDX_W-1:0] idx_top,
    output logic [IDX_W-1:0] idx_leaf,
    output logic [OFF_W-1:0] off
);
    logic [IDX_W-1:0] idx [LEVELS];

    // One index field per level, most significant level first.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign idx[l] = va[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
    end

    assign idx_top  = idx[0];
    assign idx_leaf = idx[LEVELS-1];
    assign off      = va[OFF_W-1:0];
endmodule

// File: rtl/pt_pte_decode.sv
// Decodes a table entry into present bit, frame number and permissions.
// Assumes the frame number occupies the upper PFN_W bits of the entry.
module pt_pte_decode
    import pt_walker_pkg::*;
#(
    parameter int PFN_W = 20
) (
    input  logic [PTE_W-1:0] entry,
    output logic             present,
    output logic [PFN_W-1:0] pfn,
    output perm_t            perm
);
    // Field extraction only; no state.
    always_comb begin
        present         = entry[PTE_PRESENT];
        pfn             = entry[PTE_W-1 -: PFN_W];
        perm.modified   = entry[PTE_MOD];
        perm.referenced = entry[PTE_REF];
        perm.user       = entry[PTE_USER];
        perm.writable   = entry[PTE_WRITE];
    end
endmodule

// File: rtl/pt_walk_fsm.sv
// Sequencer for one two-level walk: issues the two reads, checks presence,
// latches the result and holds it until acknowledged.
// Assumes memory answers each accepted read exactly once, in order.
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    parameter int PID_W = 8,
    localparam int VA_W  = 2*IDX_W + OFF_W,
    localparam int PFN_W = PA_W - OFF_W,
    localparam int SH    = $clog2(PTE_W/8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    input  logic [PID_W-1:0] req_pid,
    input  logic [IDX_W-1:0] idx_top,
    input  logic [IDX_W-1:0] idx_leaf,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic             ent_present,
    input  logic [PFN_W-1:0] ent_pfn,
    input  perm_t            ent_perm,
    output logic [VA_W-1:0]  va_q,
    output logic [PID_W-1:0] pid_q,
    output logic [PFN_W-1:0] leaf_pfn_q,
    output perm_t            leaf_perm_q,
    output logic             rsp_valid,
    input  logic             rsp_ack,
    output logic             rsp_fault,
    output logic             rsp_level
);
    walk_state_e      st, st_nx;
    logic [PA_W-1:0]  root_q;
    logic [PFN_W-1:0] tbl_pfn_q;
    logic             level_q;
    logic [PA_W-1:0]  top_addr, leaf_addr;

    // Entry addresses for each level.
    always_comb begin
        top_addr  = root_q + (PA_W'(idx_top) << SH);
        leaf_addr = {tbl_pfn_q, {OFF_W{1'b0}}} + (PA_W'(idx_leaf) << SH);
    end

    // Next-state decision.
    always_comb begin
        st_nx = st;
        unique case (st)
            WS_IDLE:      if (req_valid) st_nx = WS_RD_TOP;
            WS_RD_TOP:    if (mem_rd_ready) st_nx = WS_WAIT_TOP;
            WS_WAIT_TOP:  if (mem_rsp_valid) st_nx = ent_present ? WS_RD_LEAF : WS_FAULT;
            WS_RD_LEAF:   if (mem_rd_ready) st_nx = WS_WAIT_LEAF;
            WS_WAIT_LEAF: if (mem_rsp_valid) st_nx = ent_present ? WS_DONE : WS_FAULT;
            WS_DONE,
            WS_FAULT:     if (rsp_ack) st_nx = WS_IDLE;
            default:      st_nx = WS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= WS_IDLE;
        else        st <= st_nx;
    end

    // Capture of request, intermediate table frame and leaf result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            root_q      <= '0;
            pid_q       <= '0;
            tbl_pfn_q   <= '0;
            leaf_pfn_q  <= '0;
            leaf_perm_q <= '0;
            level_q     <= 1'b0;
        end else begin
            if (st == WS_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                root_q <= req_root;
                pid_q  <= req_pid;
            end
            if (st == WS_WAIT_TOP && mem_rsp_valid) begin
                tbl_pfn_q <= ent_pfn;
                level_q   <= 1'b0;
            end
            if (st == WS_WAIT_LEAF && mem_rsp_valid) begin
                leaf_pfn_q  <= ent_pfn;
                leaf_perm_q <= ent_perm;
                level_q     <= 1'b1;
            end
        end
    end

    // Port-level decode of the state.
    always_comb begin
        req_ready    = (st == WS_IDLE);
        mem_rd_valid = (st == WS_RD_TOP) || (st == WS_RD_LEAF);
        mem_rd_addr  = (st == WS_RD_LEAF) ? leaf_addr : top_addr;
        rsp_valid    = (st == WS_DONE) || (st == WS_FAULT);
        rsp_fault    = (st == WS_FAULT);
        rsp_level    = level_q;
    end

    p_top_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_WAIT_TOP && mem_rsp_valid && !ent_present) |=> (st == WS_FAULT && !rsp_level));

    p_leaf_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_WAIT_LEAF && mem_rsp_valid && !ent_present) |=> (st == WS_FAULT && rsp_level));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_IDLE && !req_valid) |=> (st == WS_IDLE));
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top: ties address split, entry decode and
// walk sequencer together and forms the physical address.
// Assumes one walk at a time and in-order single-beat read responses.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    parameter int PID_W = 8,
    localparam int VA_W  = 2*IDX_W + OFF_W,
    localparam int PFN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    input  logic [PID_W-1:0] req_pid,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ack,
    output logic             rsp_fault,
    output logic             rsp_level,
    output logic [VA_W-1:0]  rsp_vaddr,
    output logic [PID_W-1:0] rsp_pid,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic [3:0]       rsp_perm,
    output logic [PA_W-1:0]  rsp_paddr
);
    logic [VA_W-1:0]  va_q;
    logic [IDX_W-1:0] idx_top, idx_leaf;
    logic [OFF_W-1:0] off;
    logic             ent_present;
    logic [PFN_W-1:0] ent_pfn, leaf_pfn_q;
    perm_t            ent_perm, leaf_perm_q;

    pt_va_split #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .va(va_q), .idx_top(idx_top), .idx_leaf(idx_leaf), .off(off)
    );

    pt_pte_decode #(.PFN_W(PFN_W)) u_dec (
        .entry(mem_rsp_data), .present(ent_present), .pfn(ent_pfn), .perm(ent_perm)
    );

    pt_walk_fsm #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .PID_W(PID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .req_pid(req_pid),
        .idx_top(idx_top), .idx_leaf(idx_leaf),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .ent_present(ent_present), .ent_pfn(ent_pfn), .ent_perm(ent_perm),
        .va_q(va_q), .pid_q(rsp_pid),
        .leaf_pfn_q(leaf_pfn_q), .leaf_perm_q(leaf_perm_q),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    // Result formation: frame number joined with the page offset.
    always_comb begin
        rsp_vaddr = va_q;
        rsp_pfn   = leaf_pfn_q;
        rsp_perm  = leaf_perm_q;
        rsp_paddr = {leaf_pfn_q, off};
    end

    p_hold_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                     && $stable(rsp_level) && $stable(rsp_pid)));

    p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |=> (req_ready && !rsp_valid));

    p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !rsp_valid));

    p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
// Cycle-accurate behavioural reference for the walker, compared every clock.
module tb_pt_walker;
    localparam int PID_W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, req_valid, req_ready, mem_rd_valid, mem_rd_ready;
    logic mem_rsp_valid, rsp_valid, rsp_ack, rsp_fault, rsp_level;
    logic [31:0] req_vaddr, req_root, mem_rd_addr, mem_rsp_data, rsp_vaddr, rsp_paddr;
    logic [PID_W-1:0] req_pid, rsp_pid;
    logic [19:0] rsp_pfn;
    logic [3:0]  rsp_perm;

    pt_walker #(.PID_W(PID_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .req_pid(req_pid),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
        .rsp_vaddr(rsp_vaddr), .rsp_pid(rsp_pid), .rsp_pfn(rsp_pfn),
        .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Table memory: absent words read as zero (not present).
    logic [31:0] tmem [int unsigned];
    function automatic logic [31:0] rdw(input logic [31:0] a);
        return tmem.exists(a) ? tmem[a] : 32'h0;
    endfunction

    // Reference state: 0 idle, 1 top read, 2 top wait, 3 leaf read, 4 leaf wait, 5 done, 6 fault.
    int ph = 0;
    logic [31:0] m_va, m_root, m_leaf;
    logic [PID_W-1:0] m_pid;
    logic [19:0] m_tpfn;
    bit m_lvl;
    // Memory responder and stimulus knobs.
    bit rp = 0;
    int rcnt = 0;
    logic [31:0] raddr;
    int k_gap = 0, k_lat = 0, k_ackd = 0, wait_ack = 0, cyc = 0;
    bit k_noise = 0;

    task automatic cycle();
        logic [31:0] d;
        bit stray;
        stray         = k_noise && !rp && (cyc % 2 == 0);
        mem_rsp_valid = (rp && rcnt == 0) || stray;
        mem_rsp_data  = rp ? rdw(raddr) : 32'hFFFF_F0E6;
        mem_rd_ready  = ((cyc % (k_gap + 1)) == k_gap);
        rsp_ack       = (ph >= 5) && (wait_ack >= k_ackd);
        #0.1;
        chk(req_ready == (ph == 0), "R9 req_ready", 32'(req_ready), 32'(ph == 0));
        chk(mem_rd_valid == (ph == 1 || ph == 3), "R3 mem_rd_valid", 32'(mem_rd_valid), 32'(ph == 1 || ph == 3));
        chk(rsp_valid == (ph >= 5), "R8 rsp_valid", 32'(rsp_valid), 32'(ph >= 5));
        if (ph == 1) chk(mem_rd_addr == m_root + {20'h0, m_va[31:22], 2'b00}, "R1 top addr",
                         mem_rd_addr, m_root + {20'h0, m_va[31:22], 2'b00});
        if (ph == 3) chk(mem_rd_addr == {m_tpfn, 12'h0} + {20'h0, m_va[21:12], 2'b00}, "R2 leaf addr",
                         mem_rd_addr, {m_tpfn, 12'h0} + {20'h0, m_va[21:12], 2'b00});
        if (ph >= 5) begin
            chk(rsp_fault == (ph == 6), "R5 R6 rsp_fault", 32'(rsp_fault), 32'(ph == 6));
            chk(rsp_vaddr == m_va, "R7 rsp_vaddr", rsp_vaddr, m_va);
            chk(rsp_pid == m_pid, "R7 rsp_pid", 32'(rsp_pid), 32'(m_pid));
        end
        if (ph == 5) begin
            chk(rsp_paddr == {m_leaf[31:12], m_va[11:0]}, "R4 rsp_paddr", rsp_paddr, {m_leaf[31:12], m_va[11:0]});
            chk(rsp_pfn == m_leaf[31:12], "R4 rsp_pfn", 32'(rsp_pfn), 32'(m_leaf[31:12]));
            chk(rsp_perm == {m_leaf[6], m_leaf[5], m_leaf[2], m_leaf[1]}, "R4 rsp_perm",
                32'(rsp_perm), 32'({m_leaf[6], m_leaf[5], m_leaf[2], m_leaf[1]}));
        end
        if (ph == 6) chk(rsp_level == m_lvl, m_lvl ? "R6 rsp_level" : "R5 rsp_level", 32'(rsp_level), 32'(m_lvl));
        // Reference step (stray pulses only occur with no read outstanding: R10).
        d = rdw(raddr);
        case (ph)
            0: if (req_valid) begin m_va = req_vaddr; m_root = req_root; m_pid = req_pid; ph = 1; end
            1: if (mem_rd_ready) ph = 2;
            2: if (mem_rsp_valid && rp) begin
                   if (d[0]) begin m_tpfn = d[31:12]; ph = 3; end
                   else begin m_lvl = 1'b0; ph = 6; end
               end
            3: if (mem_rd_ready) ph = 4;
            4: if (mem_rsp_valid && rp) begin
                   m_leaf = d;
                   if (d[0]) ph = 5; else begin m_lvl = 1'b1; ph = 6; end
               end
            default: if (ph >= 5 && rsp_ack) ph = 0;
        endcase
        if (rp && rcnt == 0) rp = 0;
        else if (rp) rcnt--;
        if (mem_rd_valid && mem_rd_ready) begin rp = 1; raddr = mem_rd_addr; rcnt = k_lat; end
        if (ph >= 5 && !rsp_ack) wait_ack++; else wait_ack = 0;
        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] root, input logic [PID_W-1:0] pid,
                        input int gap, input int lat, input int ackd, input bit noise, input bit busy);
        int guard = 0;
        k_gap = gap; k_lat = lat; k_ackd = ackd; k_noise = noise;
        req_valid = 1'b1; req_vaddr = va; req_root = root; req_pid = pid;
        cycle();
        // R9: scramble request inputs during the walk; they must not matter.
        req_vaddr = ~va; req_root = root ^ 32'h0003_0000; req_pid = ~pid;
        while (ph != 0 && guard < 200) begin
            req_valid = busy && (ph >= 1 && ph <= 4);
            cycle();
            guard++;
        end
        chk(guard < 200, "R8 walk completes", 32'(guard), 32'd0);
        req_valid = 1'b0;
        repeat (2) cycle();
    endtask

    localparam logic [31:0] ROOT_A = 32'h0004_0000;
    localparam logic [31:0] ROOT_B = 32'h0009_0000;

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_root = '0; req_pid = '0;
        mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; rsp_ack = 1'b0;
        tmem[ROOT_A + 32'd4]     = 32'h0000_5001;
        tmem[32'h0000_500C]      = 32'h0ABC_D067;
        tmem[ROOT_A + 32'hFFC]   = 32'h0000_7003;
        tmem[32'h0000_7FFC]      = 32'hFFFF_F001;
        tmem[ROOT_A]             = 32'h0000_6001;
        tmem[32'h0000_6000]      = 32'h0012_3025;
        tmem[ROOT_A + 32'd16]    = 32'h0000_8066;
        tmem[ROOT_B + 32'd4]     = 32'h0000_A001;
        tmem[32'h0000_A00C]      = 32'h0123_4003;
        tmem[32'h0000_6004]      = 32'h0BEE_F066;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk(req_ready === 1'b1, "R11 req_ready after reset", 32'(req_ready), 32'd1);
        chk(mem_rd_valid === 1'b0, "R11 mem_rd_valid after reset", 32'(mem_rd_valid), 32'd0);
        chk(rsp_valid === 1'b0, "R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        // R10: stray responses while idle
        k_noise = 1; repeat (6) cycle(); k_noise = 0;
        walk(32'h0040_3ABC, ROOT_A, 8'h11, 0, 0, 0, 0, 0);   // R1 R2 R4 plain
        walk(32'h0040_3ABC, ROOT_A, 8'h12, 2, 3, 4, 1, 1);   // R3 R8 R9 R10 stalls, noise, busy req
        walk(32'hFFFF_FFFF, ROOT_A, 8'hFF, 1, 1, 0, 0, 0);   // last entries, all-ones offset
        walk(32'h0000_0123, ROOT_A, 8'h00, 0, 2, 1, 1, 0);   // index zero at both levels
        walk(32'h0080_0000, ROOT_A, 8'h21, 0, 0, 2, 0, 0);   // R5 absent top entry
        walk(32'h0100_0ABC, ROOT_A, 8'h22, 3, 1, 0, 1, 1);   // R5 top entry, flags set but not present
        walk(32'h0040_5000, ROOT_A, 8'h31, 1, 0, 3, 0, 0);   // R6 absent leaf
        walk(32'h0000_1FFF, ROOT_A, 8'h32, 0, 4, 0, 1, 1);   // R6 leaf flags set, not present
        walk(32'h0040_3ABC, ROOT_B, 8'h41, 0, 0, 0, 0, 0);   // R1 another root
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule